// File: doc/BRIEF.md
# Multiply-accumulate unit with HI/LO

This block is the integer multiply and multiply-accumulate execution stage of a processor pipeline. It owns a 64-bit accumulator held as two 32-bit halves, HI (upper) and LO (lower). Each issued operation takes two 32-bit operands, a signed/unsigned select and a 5-bit variant code. It then forms a plain product, a negated product, or the prior accumulator plus or minus the product, and writes the 64-bit result back into HI:LO.

Extended variants also return one half of the new accumulator so that it can be written to a general register. The variant code picks either the new HI or the new LO. The unit accepts one operation per clock. Every result, including the HI:LO update, becomes visible one cycle after issue. Any variant code outside the supported set is flagged as reserved and leaves all state untouched.

Top module: `mac_hilo_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, HI and LO read zero and res_valid, res_we and res_illegal are low.
- R2: res_valid is high in exactly the cycle after a cycle with issue_valid high, so one operation is accepted per cycle with a one-cycle latency.
- R3: Variant 0 writes the product into HI:LO. It returns res_data = 0, res_we = 0 and res_illegal = 0.
- R4: The 64-bit result is split so that LO holds bits 31:0 and HI holds bits 63:32.
- R5: Variants 0x03 and 0x0B write zero minus the product into HI:LO.
- R6: Variants 0x05 and 0x0D write the prior HI:LO plus the product. Variants 0x07 and 0x0F write the prior HI:LO minus the product. Variant 0x09 writes the product.
- R7: For variants 0x03, 0x05 and 0x07, res_data is the new LO. For 0x09, 0x0B, 0x0D and 0x0F it is the new HI. This holds whatever the value of issue_rd.
- R8: When issue_unsigned = 0, both operands are sign-extended to 64 bits before the multiply. When issue_unsigned = 1, they are zero-extended.
- R9: All 64-bit arithmetic wraps modulo 2^64, with no saturation and no trap.
- R10: Any other variant code (nonzero and outside the seven above) gives res_illegal = 1, res_we = 0 and res_data = 0. HI and LO stay unchanged.
- R11: The HI:LO value written by one operation is the accumulator input of an operation issued in the very next cycle.
- R12: res_we is high only for the seven extended variants, and only when issue_rd is nonzero.
- R13: HI and LO do not change in a cycle without issue_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_a | input | 32 | First operand |
| issue_b | input | 32 | Second operand |
| issue_unsigned | input | 1 | 1 = unsigned multiply, 0 = signed |
| issue_variant | input | 5 | Variant code |
| issue_rd | input | 5 | Destination general-register index |
| res_valid | output | 1 | Result of the previous cycle's issue |
| res_data | output | 32 | Returned half of the new accumulator |
| res_we | output | 1 | General-register write enable |
| res_illegal | output | 1 | Reserved variant code was issued |
| hi_out | output | 32 | Current HI |
| lo_out | output | 32 | Current LO |

## Verification
Every variant is driven with both signed and unsigned operands. The operands include negative values, all-ones values and zero, so that sign extension and zero extension give different products. Chains of back-to-back accumulations, including a wrap from all-ones to zero, separate a design that reads a stale HI:LO from one that forwards correctly. Reserved codes with the low bit clear, the low bit set and the top bit set each test the decode. An idle gap and a zero destination index check that state and the write enable are suppressed.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    K_MUL = 2'd0,
    K_NEG = 2'd1,
    K_ADD = 2'd2,
    K_SUB = 2'd3
  } mac_kind_e;

  typedef struct packed {
    logic      legal;
    logic      gpr_ret;
    logic      ret_hi;
    mac_kind_e kind;
  } mac_ctl_t;

  localparam int VW = 5;
  localparam logic [VW-1:0] V_PLAIN   = 5'h00;
  localparam logic [VW-1:0] V_NEG_LO  = 5'h03;
  localparam logic [VW-1:0] V_ADD_LO  = 5'h05;
  localparam logic [VW-1:0] V_SUB_LO  = 5'h07;
  localparam logic [VW-1:0] V_MUL_HI  = 5'h09;
  localparam logic [VW-1:0] V_NEG_HI  = 5'h0B;
  localparam logic [VW-1:0] V_ADD_HI  = 5'h0D;
  localparam logic [VW-1:0] V_SUB_HI  = 5'h0F;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
(
  input  logic [VW-1:0] variant,
  output mac_ctl_t      ctl
);
  always_comb begin
    ctl = '{legal: 1'b1, gpr_ret: 1'b1, ret_hi: 1'b0, kind: K_MUL};
    unique case (variant)
      V_PLAIN:  ctl = '{legal: 1'b1, gpr_ret: 1'b0, ret_hi: 1'b0, kind: K_MUL};
      V_NEG_LO: ctl.kind = K_NEG;
      V_ADD_LO: ctl.kind = K_ADD;
      V_SUB_LO: ctl.kind = K_SUB;
      V_MUL_HI: ctl = '{legal: 1'b1, gpr_ret: 1'b1, ret_hi: 1'b1, kind: K_MUL};
      V_NEG_HI: ctl = '{legal: 1'b1, gpr_ret: 1'b1, ret_hi: 1'b1, kind: K_NEG};
      V_ADD_HI: ctl = '{legal: 1'b1, gpr_ret: 1'b1, ret_hi: 1'b1, kind: K_ADD};
      V_SUB_HI: ctl = '{legal: 1'b1, gpr_ret: 1'b1, ret_hi: 1'b1, kind: K_SUB};
      default:  ctl = '{legal: 1'b0, gpr_ret: 1'b0, ret_hi: 1'b0, kind: K_MUL};
    endcase
  end
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int W = 32,
  localparam int PW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          is_unsigned,
  output logic [PW-1:0] prod
);
  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;
  logic          fill_a;
  logic          fill_b;

  // Extension bit: operand sign for signed, zero for unsigned.
  assign fill_a = ~is_unsigned & a[W-1];
  assign fill_b = ~is_unsigned & b[W-1];
  assign ext_a  = {{W{fill_a}}, a};
  assign ext_b  = {{W{fill_b}}, b};

  // Lower 2W bits of the extended product are exact in both modes.
  assign prod = ext_a * ext_b;
endmodule

// File: rtl/mac_combine.sv
module mac_combine
  import mac_pkg::*;
#(
  parameter int PW = 64
) (
  input  mac_kind_e     kind,
  input  logic [PW-1:0] acc,
  input  logic [PW-1:0] prod,
  output logic [PW-1:0] result
);
  always_comb begin
    unique case (kind)
      K_NEG:   result = '0 - prod;
      K_ADD:   result = acc + prod;
      K_SUB:   result = acc - prod;
      default: result = prod;
    endcase
  end
endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_pkg::*;
#(
  parameter int W  = 32,
  parameter int RW = 5,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [W-1:0]  issue_a,
  input  logic [W-1:0]  issue_b,
  input  logic          issue_unsigned,
  input  logic [VW-1:0] issue_variant,
  input  logic [RW-1:0] issue_rd,
  output logic          res_valid,
  output logic [W-1:0]  res_data,
  output logic          res_we,
  output logic          res_illegal,
  output logic [W-1:0]  hi_out,
  output logic [W-1:0]  lo_out
);
  mac_ctl_t      ctl;
  logic [PW-1:0] prod;
  logic [PW-1:0] next_acc;
  logic [W-1:0]  hi_q;
  logic [W-1:0]  lo_q;
  logic [W-1:0]  ret_half;

  mac_decode u_dec (
    .variant (issue_variant),
    .ctl     (ctl)
  );

  mac_multiplier #(.W(W)) u_mul (
    .a           (issue_a),
    .b           (issue_b),
    .is_unsigned (issue_unsigned),
    .prod        (prod)
  );

  // The accumulator register feeds straight back, so a result written at
  // one edge is the operand of the op issued in the following cycle.
  mac_combine #(.PW(PW)) u_cmb (
    .kind   (ctl.kind),
    .acc    ({hi_q, lo_q}),
    .prod   (prod),
    .result (next_acc)
  );

  assign ret_half = ctl.ret_hi ? next_acc[PW-1:W] : next_acc[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q        <= '0;
      lo_q        <= '0;
      res_valid   <= 1'b0;
      res_data    <= '0;
      res_we      <= 1'b0;
      res_illegal <= 1'b0;
    end else begin
      res_valid   <= issue_valid;
      res_data    <= '0;
      res_we      <= 1'b0;
      res_illegal <= 1'b0;
      if (issue_valid) begin
        if (ctl.legal) begin
          hi_q <= next_acc[PW-1:W];
          lo_q <= next_acc[W-1:0];
          if (ctl.gpr_ret) begin
            res_data <= ret_half;
            res_we   <= (issue_rd != '0);
          end
        end else begin
          res_illegal <= 1'b1;
        end
      end
    end
  end

  assign hi_out = hi_q;
  assign lo_out = lo_q;
endmodule

// File: rtl/mac_hilo_chk.sv
module mac_hilo_chk #(
  parameter int W  = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid,
  input logic [4:0]    issue_variant,
  input logic [RW-1:0] issue_rd,
  input logic          res_valid,
  input logic [W-1:0]  res_data,
  input logic          res_we,
  input logic          res_illegal,
  input logic [W-1:0]  hi_out,
  input logic [W-1:0]  lo_out
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_we && !res_illegal && hi_out == '0 && lo_out == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    issue_valid |=> res_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> !res_valid);

  p_plain_nowe_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_variant == 5'h00) |=> (!res_we && !res_illegal));

  p_ret_half_r7: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (res_data == hi_out || res_data == lo_out));

  p_illegal_hold_r10: assert property (@(posedge clk) disable iff (rst)
    res_illegal |-> ($stable(hi_out) && $stable(lo_out) && !res_we));

  p_topbit_illegal_r10: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_variant[4]) |=> res_illegal);

  p_rd_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_rd == '0) |=> !res_we);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> ($stable(hi_out) && $stable(lo_out)));
endmodule

bind mac_hilo_unit mac_hilo_chk #(.W(W), .RW(RW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .issue_valid   (issue_valid),
  .issue_variant (issue_variant),
  .issue_rd      (issue_rd),
  .res_valid     (res_valid),
  .res_data      (res_data),
  .res_we        (res_we),
  .res_illegal   (res_illegal),
  .hi_out        (hi_out),
  .lo_out        (lo_out)
);

// File: tb/mac_hilo_unit_test.sv
module mac_hilo_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] issue_a = '0;
  logic [31:0] issue_b = '0;
  logic        issue_unsigned = 1'b0;
  logic [4:0]  issue_variant = '0;
  logic [4:0]  issue_rd = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_we;
  logic        res_illegal;
  logic [31:0] hi_out;
  logic [31:0] lo_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] data;
    logic        we;
    logic        ill;
    logic [31:0] hi;
    logic [31:0] lo;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [63:0] model_acc = '0;

  always #10 clk = ~clk;

  mac_hilo_unit uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_a(issue_a),
    .issue_b(issue_b), .issue_unsigned(issue_unsigned),
    .issue_variant(issue_variant), .issue_rd(issue_rd),
    .res_valid(res_valid), .res_data(res_data), .res_we(res_we),
    .res_illegal(res_illegal), .hi_out(hi_out), .lo_out(lo_out)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Driver: computes the expected item from the requirements and issues.
  task automatic issue(input bit uns, input logic [4:0] v, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] rd, input string tag);
    exp_t e;
    logic [63:0] ea, eb, p, r;
    bit legal, hi_ret;
    ea = uns ? {32'h0, a} : {{32{a[31]}}, a};
    eb = uns ? {32'h0, b} : {{32{b[31]}}, b};
    p = ea * eb;
    legal = 1; hi_ret = 0; r = p;
    case (v)
      5'h00: r = p;
      5'h03: r = 64'd0 - p;
      5'h05: r = model_acc + p;
      5'h07: r = model_acc - p;
      5'h09: begin r = p; hi_ret = 1; end
      5'h0B: begin r = 64'd0 - p; hi_ret = 1; end
      5'h0D: begin r = model_acc + p; hi_ret = 1; end
      5'h0F: begin r = model_acc - p; hi_ret = 1; end
      default: legal = 0;
    endcase
    if (legal) model_acc = r;
    e.ill  = !legal;
    e.we   = legal && v != 5'h00 && rd != 5'h00;
    e.data = (legal && v != 5'h00) ? (hi_ret ? r[63:32] : r[31:0]) : 32'h0;
    e.hi   = model_acc[63:32];
    e.lo   = model_acc[31:0];
    e.tag  = tag;
    sb.push_back(e);
    issue_valid    = 1'b1;
    issue_unsigned = uns;
    issue_variant  = v;
    issue_a        = a;
    issue_b        = b;
    issue_rd       = rd;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  // Monitor: compares each result with the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        check(0, "R2", "result with no issue outstanding");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_data == e.data && res_we == e.we && res_illegal == e.ill &&
              hi_out == e.hi && lo_out == e.lo, e.tag,
              $sformatf("got data=%h we=%b ill=%b hi=%h lo=%h exp data=%h we=%b ill=%b hi=%h lo=%h",
                        res_data, res_we, res_illegal, hi_out, lo_out,
                        e.data, e.we, e.ill, e.hi, e.lo));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", "run did not complete");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(hi_out == 0 && lo_out == 0 && !res_valid && !res_we && !res_illegal, "R1",
          $sformatf("reset state hi=%h lo=%h v=%b exp all zero", hi_out, lo_out, res_valid));
    rst = 1'b0;
    @(negedge clk);
    check(hi_out == 0 && lo_out == 0 && !res_valid, "R1",
          $sformatf("after reset hi=%h lo=%h v=%b exp zero", hi_out, lo_out, res_valid));

    issue(0, 5'h00, 32'hFFFFFFFD, 32'd7, 5'd3, "R3 R4 plain signed");
    issue(1, 5'h00, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, "R8 plain unsigned");
    issue(0, 5'h00, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, "R8 plain signed -1*-1");
    issue(0, 5'h03, 32'd5, 32'd6, 5'd4, "R5 R7 neg lo signed");
    issue(1, 5'h0B, 32'h80000000, 32'd4, 5'd4, "R5 R7 neg hi unsigned");
    issue(0, 5'h0B, 32'h80000000, 32'd4, 5'd4, "R5 R8 neg hi signed");
    issue(0, 5'h05, 32'hFFFFFFF0, 32'd16, 5'd5, "R6 R11 add lo signed");
    issue(1, 5'h0D, 32'hFFFFFFF0, 32'd16, 5'd5, "R6 R11 add hi unsigned");
    issue(0, 5'h07, 32'd1000, 32'hFFFFFFFE, 5'd6, "R6 R11 sub lo signed");
    issue(1, 5'h0F, 32'h12345678, 32'h9ABCDEF0, 5'd6, "R6 R11 sub hi unsigned");
    issue(0, 5'h09, 32'h7FFFFFFF, 32'h80000000, 5'd7, "R6 R7 mul hi signed");
    issue(1, 5'h09, 32'h7FFFFFFF, 32'h80000000, 5'd7, "R6 R8 mul hi unsigned");
    issue(0, 5'h03, 32'd1, 32'd1, 5'd8, "R9 set all ones");
    issue(1, 5'h05, 32'd1, 32'd1, 5'd8, "R9 wrap to zero");
    issue(1, 5'h07, 32'd1, 32'd1, 5'd8, "R9 wrap below zero");
    issue(0, 5'h01, 32'd9, 32'd9, 5'd9, "R10 code 01");
    issue(1, 5'h02, 32'd9, 32'd9, 5'd9, "R10 code 02");
    issue(0, 5'h11, 32'd9, 32'd9, 5'd9, "R10 code 11");
    issue(1, 5'h1F, 32'd9, 32'd9, 5'd9, "R10 code 1F");
    issue(0, 5'h0E, 32'd9, 32'd9, 5'd9, "R10 code 0E");
    issue(0, 5'h05, 32'd3, 32'd3, 5'd0, "R12 rd zero add");
    issue(1, 5'h0D, 32'd3, 32'd3, 5'd0, "R12 rd zero add hi");
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(!res_valid && {hi_out, lo_out} == model_acc, "R13",
          $sformatf("idle hi=%h lo=%h v=%b exp %h v=0", hi_out, lo_out, res_valid, model_acc));
    for (int i = 0; i < 48; i++) begin
      logic [4:0] codes [8];
      codes = '{5'h00, 5'h03, 5'h05, 5'h07, 5'h09, 5'h0B, 5'h0D, 5'h0F};
      issue(i[0], codes[i % 8], 32'h9E3779B9 * (i + 1), 32'h7F4A7C15 ^ (i * 32'h01000193),
            5'(i), "R11 back-to-back mix");
    end
    @(negedge clk);
    check(sb.size() == 0, "R2",
          $sformatf("outstanding results %0d exp 0", sb.size()));
    finish_run();
  end
endmodule